// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Vectoring

This block is a small multicycle processor with a single 16-bit accumulator. It talks to one single-port synchronous memory: it drives an address, write data and a write strobe, and it reads a word one cycle after it presents the address. Each instruction is one 16-bit word. It passes through fetch, decode, optional operand read, execute and optional write-back. Every instruction then ends in one interrupt-check state.

When the interrupt request is high and interrupts are enabled, the interrupt-check state does four things. It copies PC and AC into shadow registers, points PC at a fixed handler address and clears the enable. It also pulses an acknowledge output for one cycle. A return instruction at the end of the handler restores PC and AC and turns interrupts back on, so the interrupted program carries on where it stopped. The interrupt source logic and its clearing are outside the block; the acknowledge pulse is the hook for them.

Top module: `acc_cpu`

## Requirements
- R1: While reset is active, PC, AC, the overflow flag and the interrupt enable are zero. The memory address is 0, no write is issued and no acknowledge is given. After reset the first fetch reads address 0.
- R2: Instruction words carry the opcode in bits [15:12] and a direct word address in bits [11:0]. Every fetch adds one to PC, so instructions run in address order unless an interrupt or a return changes PC.
- R3: Opcode 4'b0001 copies the addressed memory word into AC.
- R4: Opcode 4'b0010 writes AC to the addressed word. The write strobe is high for exactly one cycle, with the write data equal to AC.
- R5: Opcode 4'b0101 replaces AC with AC plus the addressed word, modulo 2^16.
- R6: Every 4'b0101 instruction updates the overflow output. It is 1 exactly when the two operands have the same sign and the sum's sign differs from theirs, and 0 otherwise.
- R7: Opcodes other than 4'b0001, 4'b0010, 4'b0101, 4'b1110 and 4'b1111 leave AC unchanged and write no memory.
- R8: After each instruction, if the request is high and interrupts are enabled, the block does the following. It saves PC and AC, loads PC with the parameter VEC (default 12'h800) and clears the enable. It raises the acknowledge output for one cycle. The next fetch comes from VEC.
- R9: With the enable clear, a high request is ignored. This holds after reset and inside a handler.
- R10: Opcode 4'b1111 restores PC and AC from the shadow registers and sets the enable.
- R11: Opcode 4'b1110 sets the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Read data, valid the cycle after the address |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe |
| irq_ack | output | 1 | One-cycle pulse when the handler is entered |
| ovf | output | 1 | Signed overflow of the last add |

## Verification
An instruction takes the following number of cycles from its fetch address until the next fetch begins:
- load or add: eight cycles
- store: seven cycles
- any other opcode: six cycles

An interrupt entry puts VEC on the address bus two cycles after the acknowledge pulse. The bench therefore samples the address exactly two falling edges after it sees the acknowledge.

Results in memory and on the overflow output are checked only after a run long enough for every instruction of the program to have retired, with slack to spare. The bench counts write strobes and acknowledge pulses on every falling edge, so the checks never hinge on a single sampling instant.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter logic [AW-1:0] VEC = 12'h800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          irq_ack,
  output logic          ovf
);
  localparam int OPW = DW - AW;
  localparam logic [OPW-1:0] OP_LD  = 4'b0001;
  localparam logic [OPW-1:0] OP_ST  = 4'b0010;
  localparam logic [OPW-1:0] OP_ADD = 4'b0101;
  localparam logic [OPW-1:0] OP_EI  = 4'b1110;
  localparam logic [OPW-1:0] OP_RET = 4'b1111;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_DEC, S_OP1, S_OP2, S_EXE, S_WB, S_INT
  } st_t;

  st_t st;
  logic [AW-1:0] pc, mar, spc;
  logic [DW-1:0] ir, mbr, ac, sac, sum;
  logic ie;
  logic [OPW-1:0] op;

  assign op        = ir[DW-1:AW];
  assign sum       = ac + mbr;
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (st == S_WB);
  assign irq_ack   = (st == S_INT) && irq && ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_F1;
      pc  <= '0;
      mar <= '0;
      spc <= '0;
      ir  <= '0;
      mbr <= '0;
      ac  <= '0;
      sac <= '0;
      ie  <= 1'b0;
      ovf <= 1'b0;
    end else begin
      case (st)
        S_F1: begin
          mar <= pc;
          st  <= S_F2;
        end
        S_F2: st <= S_F3;
        S_F3: begin
          mbr <= mem_rdata;
          ir  <= mem_rdata;
          pc  <= pc + 1'b1;
          st  <= S_DEC;
        end
        S_DEC: begin
          mar <= ir[AW-1:0];
          st  <= (op == OP_LD || op == OP_ADD) ? S_OP1 : S_EXE;
        end
        S_OP1: st <= S_OP2;
        S_OP2: begin
          mbr <= mem_rdata;
          st  <= S_EXE;
        end
        S_EXE: begin
          st <= S_INT;
          case (op)
            OP_LD: ac <= mbr;
            OP_ADD: begin
              ac  <= sum;
              ovf <= (ac[DW-1] == mbr[DW-1]) && (sum[DW-1] != ac[DW-1]);
            end
            OP_ST: begin
              mbr <= ac;
              st  <= S_WB;
            end
            OP_EI: ie <= 1'b1;
            OP_RET: begin
              pc <= spc;
              ac <= sac;
              ie <= 1'b1;
            end
            default: ;
          endcase
        end
        S_WB: st <= S_INT;
        S_INT: begin
          if (irq && ie) begin
            spc <= pc;
            sac <= ac;
            pc  <= VEC;
            ie  <= 1'b0;
          end
          st <= S_F1;
        end
        default: st <= S_F1;
      endcase
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F3) |=> (pc == $past(pc) + 1'b1));

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_wdata_ac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == ac));

  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (pc == VEC && !ie && spc == $past(pc) && sac == $past(ac)));

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INT && !ie) |=> (pc == $past(pc)));

  p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXE && op == OP_RET) |=> (pc == $past(spc) && ac == $past(sac) && ie));
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        irq_ack;
  logic        ovf;

  logic [15:0] mem [0:4095];
  int total = 0;
  int fails = 0;
  int wcnt = 0;
  int ackcnt = 0;
  int cyc = 0;
  logic [1:0]  ack_d = 2'b00;
  logic [11:0] addr_after_ack = '0;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .irq_ack(irq_ack), .ovf(ovf)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst_n && mem_we) wcnt++;
    if (rst_n && irq_ack) ackcnt++;
    ack_d <= {ack_d[0], irq_ack};
    if (ack_d[1]) addr_after_ack = mem_addr;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      total++;
      $display("FAIL watchdog: run did not end act=%0d exp=<150000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_ovf(input logic [15:0] x, input logic [15:0] y);
    logic [15:0] s;
    s = x + y;
    return (x[15] == y[15]) && (s[15] != x[15]);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(input int n);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    wcnt = 0;
    ackcnt = 0;
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic arith_case(input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] c, input logic irq_level);
    logic [15:0] s1, s2;
    clear_mem();
    mem[0] = 16'h1100;
    mem[1] = 16'h5101;
    mem[2] = 16'h2102;
    mem[3] = 16'h3123;
    mem[4] = 16'h2103;
    mem[5] = 16'h5104;
    mem[6] = 16'h2105;
    mem[16'h100] = a;
    mem[16'h101] = b;
    mem[16'h104] = c;
    mem[16'h123] = 16'h5A5A;
    s1 = a + b;
    s2 = s1 + c;
    irq = irq_level;
    run(120);
    chk("R3/R5 load then add stored", mem[16'h102], s1);
    chk("R7 undefined opcode kept AC", mem[16'h103], s1);
    chk("R7 undefined opcode wrote nothing", mem[16'h123], 16'h5A5A);
    chk("R5 wrap sum", mem[16'h105], s2);
    chk("R6 overflow of last add", {15'd0, ovf}, {15'd0, exp_ovf(s1, c)});
    chk("R4 write strobe count", wcnt[15:0], 16'd3);
    if (irq_level) chk("R9 request ignored with enable clear", ackcnt[15:0], 16'd0);
    irq = 1'b0;
  endtask

  task automatic irq_case(input logic [15:0] a, input logic [15:0] b, input logic [15:0] x);
    clear_mem();
    mem[0] = 16'h1100;
    mem[1] = 16'hE000;
    mem[2] = 16'h5101;
    mem[3] = 16'h2102;
    mem[12'h800] = 16'h1110;
    mem[12'h801] = 16'h2111;
    mem[12'h802] = 16'hF000;
    mem[16'h100] = a;
    mem[16'h101] = b;
    mem[16'h110] = x;
    addr_after_ack = '0;
    irq = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    wcnt = 0;
    ackcnt = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (mem_addr == 12'h802) irq = 1'b0;
    end
    irq = 1'b0;
    chk("R8 handler entered once", ackcnt[15:0], 16'd1);
    chk("R8 fetch from vector after ack", {4'd0, addr_after_ack}, 16'h0800);
    chk("R9 handler ran with request high", mem[16'h111], x);
    chk("R10 AC and PC restored after return", mem[16'h102], a + b);
    chk("R11 enable let interrupt in, write count", wcnt[15:0], 16'd2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_mem();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset address", {4'd0, mem_addr}, 16'h0000);
    chk("R1 reset no write", {15'd0, mem_we}, 16'd0);
    chk("R1 reset overflow", {15'd0, ovf}, 16'd0);
    chk("R1 reset no ack", {15'd0, irq_ack}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 R2 first fetch address", {4'd0, mem_addr}, 16'h0000);

    arith_case(16'h7FFF, 16'h0000, 16'h0001, 1'b0);
    arith_case(16'hFFFF, 16'h0000, 16'h0001, 1'b0);
    arith_case(16'h8000, 16'h0000, 16'h8000, 1'b0);
    arith_case(16'h1234, 16'h4321, 16'h0000, 1'b1);
    for (int k = 0; k < 8; k++)
      arith_case($urandom, $urandom, $urandom, k[0]);

    irq_case(16'h0003, 16'h0004, 16'hBEEF);
    for (int k = 0; k < 3; k++)
      irq_case($urandom, $urandom, $urandom);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule